// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits beside one processor and decides whether that processor should be interrupted. A routing layer outside the block offers it at most one pending external source at a time, as a source number and a priority. Software on the processor can also post one inter-processor interrupt by giving it a priority. Priorities are numeric, and a smaller number is more favoured. The block holds the processor's current priority. It raises its interrupt line whenever the most favoured candidate has a priority numerically below that current priority.

Software uses a small word-addressed register window. Reading the accept register hands over the winning source and moves the processor priority to that source's priority in the same access. This masks the source and every less favoured one. Writing the accept register as a full word ends the interrupt: it loads a new processor priority and passes the finished source number to the routing layer. A write to the top byte alone changes the priority and nothing else. A poll register reports the same information with no side effect. The external source stays asserted at the input until the routing layer removes it, so a source held off by the priority is presented again once the priority is lowered.

Top module: `irq_presenter`

## Requirements
- R1: After reset the processor priority is 0x00, the inter-processor request holds 0xFF (cancelled), irq_out is low, eoi_valid is low, a poll read returns 0x00000000 and a read of offset 0xC returns 0xFF000000.
- R2: A read at offset 0x0 (poll) returns the processor priority in bits 31:24 and the presented source number in bits 23:0, or 0 there when nothing is deliverable. It changes no state.
- R3: A candidate is deliverable only when its priority is numerically less than the processor priority. irq_out is high exactly when some candidate is deliverable. Priority 0x00 therefore blocks everything, and 0xFF blocks only sources of priority 0xFF.
- R4: A write at offset 0xC with byte enable 3 (bits 31:24) set stores bits 31:24 as the inter-processor priority. While that priority is deliverable the presented source number is 2. The value 0xFF cancels the request, and a read of 0xC returns the stored priority in bits 31:24 with zeros below.
- R5: When both candidates are deliverable, the one with the numerically smaller priority is presented. On equal priorities the inter-processor interrupt (source 2) is presented.
- R6: A read at offset 0x4 (accept) returns the same word a poll would return in that cycle. If a source was presented, the processor priority becomes that source's priority from the next cycle, and irq_out drops unless a more favoured candidate is present.
- R7: An accept read with nothing deliverable returns source 0 and leaves the processor priority unchanged.
- R8: A write at offset 0x4 with all four byte enables set loads bits 31:24 into the processor priority. In the cycle after the write, eoi_valid is high for one cycle and eoi_src carries bits 23:0 of the written word.
- R9: A write at offset 0x4 with only byte enable 3 set loads bits 31:24 into the processor priority and leaves eoi_valid low.
- R10: After an end-of-interrupt restores a priority above a source that is still pending, irq_out rises again and that source is presented.
- R11: Writes at offset 0x8, writes at offset 0x4 with any other byte-enable pattern, and writes at offset 0xC without byte enable 3 change nothing. A read of 0x8 returns 0.
- R12: An external source offered with source number 0 is never presented and never raises irq_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_valid | input | 1 | An external source is pending |
| ext_src | input | 24 | Number of the pending external source |
| ext_prio | input | 8 | Priority of the pending external source |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 4 | Byte address in the window; word offsets 0x0, 0x4, 0x8, 0xC |
| req_be | input | 4 | Byte enables; bit 3 covers bits 31:24 |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current access, same cycle |
| irq_out | output | 1 | Interrupt request to the processor |
| eoi_valid | output | 1 | One-cycle end-of-interrupt notice to the routing layer |
| eoi_src | output | 24 | Source number ended, valid with eoi_valid |

## Verification
The bench sweeps processor priority against source priority around every boundary, including each value one above and one below the current priority. An off-by-one comparison would deliver a source of equal priority, or would let 0xFF through. A grid of inter-processor and external priorities targets the tie rule, which a design with a reversed comparator would resolve toward the external source. An accept followed by a nested accept and an end-of-interrupt checks that the priority rises and falls. A design that forgot to raise the priority would keep the line high, and one that dropped the pending state would not reassert. Top-byte writes, odd byte enables and the reserved slot check that only a full-word write signals an end-of-interrupt.

// File: rtl/irq_pres_pkg.sv
package irq_pres_pkg;

   typedef enum logic [1:0] {
      OFS_POLL   = 2'd0,
      OFS_ACCEPT = 2'd1,
      OFS_RSVD   = 2'd2,
      OFS_IPI    = 2'd3
   } reg_ofs_e;

   localparam int unsigned SRC_NONE = 0;
   localparam int unsigned SRC_IPI  = 2;

endpackage

// File: rtl/irq_pres_arb.sv
module irq_pres_arb #(
   parameter int unsigned SRC_W      = 24,
   parameter int unsigned PRIO_W     = 8,
   parameter bit          IPI_ON_TIE = 1'b1
) (
   input  logic [PRIO_W-1:0] cppr,
   input  logic [PRIO_W-1:0] ipi_prio,
   input  logic              ext_valid,
   input  logic [SRC_W-1:0]  ext_src,
   input  logic [PRIO_W-1:0] ext_prio,
   output logic              sel_valid,
   output logic [SRC_W-1:0]  sel_src,
   output logic [PRIO_W-1:0] sel_prio
);
   import irq_pres_pkg::*;

   logic ipi_ok;
   logic ext_ok;
   logic ipi_first;
   logic pick_ipi;

   assign ipi_ok = (ipi_prio < cppr);
   assign ext_ok = ext_valid && (ext_src != SRC_W'(SRC_NONE)) && (ext_prio < cppr);

   generate
      if (IPI_ON_TIE) begin : g_tie_ipi
         assign ipi_first = (ipi_prio <= ext_prio);
      end else begin : g_tie_ext
         assign ipi_first = (ipi_prio < ext_prio);
      end
   endgenerate

   assign pick_ipi = ipi_ok && (!ext_ok || ipi_first);

   always_comb begin
      if (pick_ipi) begin
         sel_valid = 1'b1;
         sel_src   = SRC_W'(SRC_IPI);
         sel_prio  = ipi_prio;
      end else if (ext_ok) begin
         sel_valid = 1'b1;
         sel_src   = ext_src;
         sel_prio  = ext_prio;
      end else begin
         sel_valid = 1'b0;
         sel_src   = SRC_W'(SRC_NONE);
         sel_prio  = '1;
      end
   end

endmodule

// File: rtl/irq_pres_regs.sv
module irq_pres_regs #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PRIO_W = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [DATA_W/8-1:0]        req_be,
   input  logic [DATA_W-1:0]          req_wdata,
   input  logic                       sel_valid,
   input  logic [DATA_W-PRIO_W-1:0]   sel_src,
   input  logic [PRIO_W-1:0]          sel_prio,
   output logic [PRIO_W-1:0]          cppr,
   output logic [PRIO_W-1:0]          ipi_prio,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       eoi_valid,
   output logic [DATA_W-PRIO_W-1:0]   eoi_src
);
   import irq_pres_pkg::*;

   localparam int unsigned SRC_W    = DATA_W - PRIO_W;
   localparam int unsigned BE_W     = DATA_W / 8;
   localparam int unsigned PRIO_LNS = PRIO_W / 8;
   localparam logic [BE_W-1:0] BE_TOP = {{PRIO_LNS{1'b1}}, {(BE_W-PRIO_LNS){1'b0}}};

   reg_ofs_e          ofs;
   logic              rd_acc;
   logic              wr_acc_full;
   logic              wr_acc_top;
   logic              wr_ipi;
   logic [PRIO_W-1:0] wtop;

   assign ofs         = reg_ofs_e'(req_addr[3:2]);
   assign wtop        = req_wdata[DATA_W-1 -: PRIO_W];
   assign rd_acc      = req_valid && !req_write && (ofs == OFS_ACCEPT);
   assign wr_acc_full = req_valid && req_write && (ofs == OFS_ACCEPT) && (&req_be);
   assign wr_acc_top  = req_valid && req_write && (ofs == OFS_ACCEPT) && (req_be == BE_TOP);
   assign wr_ipi      = req_valid && req_write && (ofs == OFS_IPI) && (&req_be[BE_W-1 -: PRIO_LNS]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cppr      <= '0;
         ipi_prio  <= '1;
         eoi_valid <= 1'b0;
         eoi_src   <= '0;
      end else begin
         eoi_valid <= wr_acc_full;
         if (wr_acc_full) begin
            eoi_src <= req_wdata[SRC_W-1:0];
         end
         if (wr_acc_full || wr_acc_top) begin
            cppr <= wtop;
         end else if (rd_acc && sel_valid) begin
            cppr <= sel_prio;
         end
         if (wr_ipi) begin
            ipi_prio <= wtop;
         end
      end
   end

   always_comb begin
      unique case (ofs)
         OFS_POLL,
         OFS_ACCEPT: rd_data = {cppr, sel_src};
         OFS_IPI:    rd_data = {ipi_prio, {SRC_W{1'b0}}};
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PRIO_W     = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          IPI_ON_TIE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ext_valid,
   input  logic [DATA_W-PRIO_W-1:0] ext_src,
   input  logic [PRIO_W-1:0]        ext_prio,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W/8-1:0]      req_be,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     irq_out,
   output logic                     eoi_valid,
   output logic [DATA_W-PRIO_W-1:0] eoi_src
);
   localparam int unsigned SRC_W = DATA_W - PRIO_W;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_data_w
         $error("DATA_W must be a whole number of bytes");
      end
      if (PRIO_W % 8 != 0 || PRIO_W >= DATA_W) begin : g_bad_prio_w
         $error("PRIO_W must be whole bytes and narrower than DATA_W");
      end
      if (SRC_W < 2) begin : g_bad_src_w
         $error("source field too narrow for the reserved numbers");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("ADDR_W must cover four word offsets");
      end
   endgenerate

   logic [PRIO_W-1:0] cppr;
   logic [PRIO_W-1:0] ipi_prio;
   logic              sel_valid;
   logic [SRC_W-1:0]  sel_src;
   logic [PRIO_W-1:0] sel_prio;

   irq_pres_arb #(
      .SRC_W      (SRC_W),
      .PRIO_W     (PRIO_W),
      .IPI_ON_TIE (IPI_ON_TIE)
   ) u_arb (
      .cppr      (cppr),
      .ipi_prio  (ipi_prio),
      .ext_valid (ext_valid),
      .ext_src   (ext_src),
      .ext_prio  (ext_prio),
      .sel_valid (sel_valid),
      .sel_src   (sel_src),
      .sel_prio  (sel_prio)
   );

   irq_pres_regs #(
      .DATA_W (DATA_W),
      .PRIO_W (PRIO_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .req_wdata (req_wdata),
      .sel_valid (sel_valid),
      .sel_src   (sel_src),
      .sel_prio  (sel_prio),
      .cppr      (cppr),
      .ipi_prio  (ipi_prio),
      .rd_data   (rd_data),
      .eoi_valid (eoi_valid),
      .eoi_src   (eoi_src)
   );

   assign irq_out = sel_valid;

endmodule

// File: rtl/irq_pres_chk.sv
module irq_pres_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PRIO_W = 8,
   parameter int unsigned ADDR_W = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_write,
   input logic [ADDR_W-1:0]        req_addr,
   input logic [DATA_W/8-1:0]      req_be,
   input logic [DATA_W-1:0]        req_wdata,
   input logic                     irq_out,
   input logic                     eoi_valid,
   input logic [DATA_W-PRIO_W-1:0] eoi_src,
   input logic [PRIO_W-1:0]        cppr,
   input logic [PRIO_W-1:0]        ipi_prio,
   input logic [DATA_W-PRIO_W-1:0] sel_src,
   input logic [PRIO_W-1:0]        sel_prio
);
   localparam int unsigned SRC_W = DATA_W - PRIO_W;

   logic acc_rd;
   logic poll_rd;
   logic acc_full_wr;
   logic ipi_top_wr;

   assign acc_rd      = req_valid && !req_write && (req_addr[3:2] == 2'd1);
   assign poll_rd     = req_valid && !req_write && (req_addr[3:2] == 2'd0);
   assign acc_full_wr = req_valid && req_write && (req_addr[3:2] == 2'd1) && (&req_be);
   assign ipi_top_wr  = req_valid && req_write && (req_addr[3:2] == 2'd3) && req_be[DATA_W/8-1];

   a_r2_poll_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      poll_rd |=> ($stable(cppr) && $stable(ipi_prio)));

   a_r3_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (cppr == '0) |-> !irq_out);

   a_r4_ipi_store: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_top_wr |=> (ipi_prio == $past(req_wdata[DATA_W-1 -: PRIO_W])));

   a_r6_accept_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && irq_out) |=> (cppr == $past(sel_prio)));

   a_r8_eoi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      acc_full_wr |=> (eoi_valid && (eoi_src == $past(req_wdata[SRC_W-1:0]))));

   a_r9_no_stray_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_full_wr |=> !eoi_valid);

   a_r12_never_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (sel_src != '0));

endmodule

bind irq_presenter irq_pres_chk #(
   .DATA_W (DATA_W),
   .PRIO_W (PRIO_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_be    (req_be),
   .req_wdata (req_wdata),
   .irq_out   (irq_out),
   .eoi_valid (eoi_valid),
   .eoi_src   (eoi_src),
   .cppr      (cppr),
   .ipi_prio  (ipi_prio),
   .sel_src   (sel_src),
   .sel_prio  (sel_prio)
);

// File: tb/irq_presenter_tb.sv
module irq_presenter_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_valid = 1'b0;
   logic [23:0] ext_src = '0;
   logic [7:0]  ext_prio = '1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rd_data;
   logic        irq_out;
   logic        eoi_valid;
   logic [23:0] eoi_src;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_presenter dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_valid (ext_valid),
      .ext_src   (ext_src),
      .ext_prio  (ext_prio),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .req_wdata (req_wdata),
      .rd_data   (rd_data),
      .irq_out   (irq_out),
      .eoi_valid (eoi_valid),
      .eoi_src   (eoi_src)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = 4'hF;
      #1 d = rd_data;
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be,
                         output logic ev, output logic [23:0] es);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
      @(posedge clk);
      #1 ev = eoi_valid; es = eoi_src;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic set_ext(input logic v, input logic [23:0] s, input logic [7:0] p);
      @(negedge clk);
      ext_valid = v; ext_src = s; ext_prio = p;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic        ev;
      logic [23:0] es;
      int vals[7] = '{0, 3, 4, 5, 6, 254, 255};

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      #1 check("R1 irq", {31'd0, irq_out}, 32'd0);
      check("R1 eoi", {31'd0, eoi_valid}, 32'd0);
      bus_rd(4'h0, d); check("R1 poll", d, 32'h0000_0000);
      bus_rd(4'hC, d); check("R1 ipi reg", d, 32'hFF00_0000);

      // R3 sweep of processor priority against source priority
      for (int c = 0; c < 256; c += 17) begin
         bus_wr(4'h4, {c[7:0], 24'h0}, 4'b1000, ev, es);
         check("R9 top write no eoi", {31'd0, ev}, 32'd0);
         for (int k = 0; k < 19; k++) begin
            int p;
            logic hit;
            p = (k < 16) ? k * 17 : c + k - 17;
            if (p < 0 || p > 255) continue;
            set_ext(1'b1, 24'h00ABCD, p[7:0]);
            hit = (p < c);
            check("R3 irq", {31'd0, irq_out}, {31'd0, hit});
            bus_rd(4'h0, d);
            check("R2 R3 poll", d, {c[7:0], hit ? 24'h00ABCD : 24'h0});
         end
      end
      // R2 poll left priority untouched
      bus_rd(4'h0, d); check("R2 stable", d[31:24], 32'hFF);

      // R12 source 0 ignored
      set_ext(1'b1, 24'h0, 8'h01);
      check("R12 irq", {31'd0, irq_out}, 32'd0);
      bus_rd(4'h0, d); check("R12 poll", d, 32'hFF00_0000);

      // R4 R5 grid of IPI versus external priorities
      foreach (vals[i]) begin
         foreach (vals[j]) begin
            logic iok, eok;
            logic [23:0] exp_s;
            bus_wr(4'hC, {vals[i][7:0], 24'h0}, 4'b1000, ev, es);
            set_ext(1'b1, 24'h000777, vals[j][7:0]);
            iok = vals[i] < 255;
            eok = vals[j] < 255;
            if (iok && (!eok || vals[i] <= vals[j])) exp_s = 24'd2;
            else if (eok) exp_s = 24'h000777;
            else exp_s = 24'd0;
            bus_rd(4'h0, d); check("R5 R4 winner", d, {8'hFF, exp_s});
            check("R3 R5 irq", {31'd0, irq_out}, {31'd0, iok || eok});
         end
      end
      bus_wr(4'hC, 32'h0500_0000, 4'b1000, ev, es);
      bus_rd(4'hC, d); check("R4 ipi reg", d, 32'h0500_0000);
      bus_wr(4'hC, 32'h0100_0000, 4'b0111, ev, es);
      bus_rd(4'hC, d); check("R11 ipi no top lane", d, 32'h0500_0000);
      bus_wr(4'hC, 32'hFF00_0000, 4'b1000, ev, es);
      bus_rd(4'hC, d); check("R4 cancel", d, 32'hFF00_0000);

      // R6 accept, R8 eoi, R10 reassert
      set_ext(1'b1, 24'h123456, 8'h05);
      bus_rd(4'h4, d); check("R6 accept word", d, 32'hFF12_3456);
      #1 check("R6 irq drops", {31'd0, irq_out}, 32'd0);
      bus_rd(4'h0, d); check("R6 priority raised", d, 32'h0500_0000);
      // nested IPI more favoured
      bus_wr(4'hC, 32'h0400_0000, 4'b1000, ev, es);
      check("R6 nested irq", {31'd0, irq_out}, 32'd1);
      bus_rd(4'h4, d); check("R6 nested accept", d, 32'h0500_0002);
      #1 check("R6 nested drop", {31'd0, irq_out}, 32'd0);
      bus_wr(4'hC, 32'hFF00_0000, 4'b1000, ev, es);
      bus_wr(4'h4, 32'h0500_0002, 4'hF, ev, es);
      check("R8 eoi pulse", {31'd0, ev}, 32'd1);
      check("R8 eoi src", {8'd0, es}, 32'd2);
      @(posedge clk); #1 check("R8 pulse one cycle", {31'd0, eoi_valid}, 32'd0);
      bus_rd(4'h0, d); check("R8 priority restored", d, 32'h0500_0000);
      bus_wr(4'h4, 32'hFF12_3456, 4'hF, ev, es);
      check("R8 eoi src ext", {7'd0, ev, es}, 32'h0112_3456);
      check("R10 reassert", {31'd0, irq_out}, 32'd1);
      bus_rd(4'h0, d); check("R10 poll", d, 32'hFF12_3456);

      // R7 accept with nothing deliverable
      set_ext(1'b0, 24'h0, 8'hFF);
      bus_wr(4'h4, 32'h3000_0000, 4'b1000, ev, es);
      bus_rd(4'h4, d); check("R7 accept empty", d, 32'h3000_0000);
      bus_rd(4'h0, d); check("R7 unchanged", d, 32'h3000_0000);

      // R11 ignored writes
      bus_wr(4'h8, 32'hFFFF_FFFF, 4'hF, ev, es);
      check("R11 rsvd no eoi", {31'd0, ev}, 32'd0);
      bus_rd(4'h8, d); check("R11 rsvd read", d, 32'h0);
      bus_wr(4'h4, 32'h7700_1234, 4'b0011, ev, es);
      check("R11 partial no eoi", {31'd0, ev}, 32'd0);
      bus_rd(4'h0, d); check("R11 partial unchanged", d, 32'h3000_0000);
      bus_rd(4'hC, d); check("R11 ipi unchanged", d, 32'hFF00_0000);

      // R3 zero blocks even the most favoured sources
      bus_wr(4'h4, 32'h0000_0000, 4'b1000, ev, es);
      bus_wr(4'hC, 32'h0000_0000, 4'b1000, ev, es);
      set_ext(1'b1, 24'h000042, 8'h00);
      check("R3 zero blocks", {31'd0, irq_out}, 32'd0);
      bus_rd(4'h4, d); check("R3 R7 zero accept", d, 32'h0000_0000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule